// File: doc/BRIEF.md
# Dual-Width Microprocessor Bus Front End

This block sits at the host-facing edge of a character display controller. A host microprocessor runs bus cycles using a register-select line, a read/write line, an enable strobe and an 8-bit data bus. The block receives a copy of the enable strobe that has already been synchronised to the controller clock. From that copy it finds the start and the end of each cycle. It sorts each cycle into one of four kinds from the select and direction lines: instruction write, status read, data write or data read. Completed writes go to the instruction executor as one-cycle strobes that carry a full byte.

The bus runs either a full byte per transfer or a nibble per transfer. In nibble mode only the upper four data lines are used, and every byte takes two transfers, upper nibble first. The block keeps one phase pointer that is shared by reads and writes. It raises a byte strobe only after the second nibble, so the executor can turn busy only once the whole byte has arrived. The bus width is taken from the function-set instruction that passes through the block.

Reads return either the busy flag together with the address counter, or the contents of a data register that the executor filled in advance. Writes are dropped while the controller is busy. The busy indication the host sees also stays high for a short guard window after the executor's busy falls, which gives the required spacing before the next command.

Top module: `mbus_front`

## Requirements
- R1: After a synchronous reset the bus width is 8-bit (`wide_mode`=1), `bus_doe`=0, and no strobe is active.
- R2: In 8-bit mode, an instruction write (select=0, read=0) produces a single-cycle `cmd_vld` whose `cmd_byte` equals the byte held on the bus while enable was high. The strobe appears in the clock cycle after the falling edge of enable is seen.
- R3: A data write (select=1, read=0) produces a single-cycle `wdat_vld` carrying the written byte. It never coincides with `cmd_vld` or `rdat_ack`.
- R4: A status read (select=0, read=1) drives `bus_doe`=1 while enable is high. It returns the effective busy flag on bit 7 and the 7-bit address counter on bits 6..0.
- R5: A data read (select=1, read=1) returns `rdreg_in`. When the byte completes, it pulses `rdat_ack` for one cycle so the data register can be refilled.
- R6: An instruction byte with bits 7..5 = 001 sets the bus width from bit 4: 1 gives 8-bit and 0 gives nibble mode. The new width takes effect from the next transfer. The phase pointer is at the upper-nibble phase after any width change.
- R7: In nibble mode, a write takes its nibble from data bits 7..4. The first transfer produces no strobe. The second transfer produces the strobe with the byte {first nibble, second nibble}.
- R8: In nibble mode, a read places the upper nibble of the read value on bits 7..4 in the first transfer and the lower nibble there in the second, with bits 3..0 driven 0. The value is captured at the start of the first transfer.
- R9: A write whose enable falls while the effective busy flag is high is ignored. It produces no strobe and leaves the nibble phase unchanged.
- R10: Status reads are serviced while busy and report bit 7 = 1.
- R11: After `busy_in` falls, the effective busy flag stays high for the following HOLD_CYC+1 clock edges. Writes are ignored during that window and accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Synchronised bus enable strobe |
| bus_sel | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rd | input | 1 | Direction: 1 read, 0 write |
| bus_din | input | 8 | Data bus from host |
| bus_dout | output | 8 | Read data toward the pad drivers |
| bus_doe | output | 1 | Read-data output enable |
| busy_in | input | 1 | Busy flag from the instruction executor |
| ac_in | input | 7 | Current address counter |
| rdreg_in | input | 8 | Prefetched data register contents |
| cmd_vld | output | 1 | Instruction byte strobe |
| cmd_byte | output | 8 | Instruction byte |
| wdat_vld | output | 1 | Write-data byte strobe |
| wdat_byte | output | 8 | Write-data byte |
| rdat_ack | output | 1 | Data read byte completed |
| wide_mode | output | 1 | Current width: 1 8-bit, 0 nibble |

## Verification
The bench goes after nibble assembly and checks that the first nibble raises no strobe. A design with a misplaced phase pointer would strobe early or swap the nibbles. It checks that a write dropped while busy does not advance the phase, since a wrong design would put every later byte out of step by one nibble. It checks the guard window right after busy falls, where a design without the hold would accept a command too soon and report ready early. It also checks switching width in both directions, and status reads taken during busy, which a wrong design would block or report as ready.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  // encoding is {select, read}
  typedef enum logic [1:0] {
    CYC_IWR = 2'b00,
    CYC_SRD = 2'b01,
    CYC_DWR = 2'b10,
    CYC_DRD = 2'b11
  } cyc_kind_t;
endpackage

// File: rtl/mbus_edge.sv
module mbus_edge
  import mbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic [DW-1:0] din_i,
  output logic          rise_o,
  output logic          fall_o,
  output cyc_kind_t     kind_o,
  output logic [DW-1:0] cap_o
);
  logic en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      kind_o <= CYC_IWR;
      cap_o  <= '0;
    end else begin
      en_d <= en_i;
      if (en_i) begin
        kind_o <= cyc_kind_t'({sel_i, rd_i});
        cap_o  <= din_i;
      end
    end
  end

  assign rise_o = en_i & ~en_d;
  assign fall_o = en_d & ~en_i;
endmodule

// File: rtl/mbus_hold.sv
module mbus_hold #(
  parameter int HOLD_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          busy_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_d <= 1'b0;
      cnt    <= '0;
    end else begin
      busy_d <= busy_i;
      if (busy_d && !busy_i)
        cnt <= CW'(HOLD_CYC);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign busy_o = busy_i | busy_d | (cnt != '0);
endmodule

// File: rtl/mbus_assemble.sv
module mbus_assemble
  import mbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_i,
  input  cyc_kind_t     kind_i,
  input  logic [DW-1:0] cap_i,
  input  logic          busy_i,
  output logic          cmd_vld_o,
  output logic [DW-1:0] cmd_o,
  output logic          wdat_vld_o,
  output logic [DW-1:0] wdat_o,
  output logic          rack_o,
  output logic          wide_o,
  output logic          lo_o
);
  localparam int NW = DW / 2;
  localparam int DL_BIT = DW - 4;

  logic [NW-1:0] hi_q;
  logic          is_wr, take, done;
  logic [DW-1:0] full;

  always_comb begin
    is_wr = (kind_i == CYC_IWR) || (kind_i == CYC_DWR);
    take  = fall_i && !(is_wr && busy_i);
    done  = take && (wide_o || lo_o);
    full  = wide_o ? cap_i : {hi_q, cap_i[DW-1 -: NW]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      lo_o       <= 1'b0;
      wide_o     <= 1'b1;
      cmd_vld_o  <= 1'b0;
      cmd_o      <= '0;
      wdat_vld_o <= 1'b0;
      wdat_o     <= '0;
      rack_o     <= 1'b0;
    end else begin
      cmd_vld_o  <= 1'b0;
      wdat_vld_o <= 1'b0;
      rack_o     <= 1'b0;
      if (take && !done) begin
        hi_q <= cap_i[DW-1 -: NW];
        lo_o <= 1'b1;
      end
      if (done) begin
        lo_o <= 1'b0;
        unique case (kind_i)
          CYC_IWR: begin
            cmd_vld_o <= 1'b1;
            cmd_o     <= full;
            if (full[DW-1 -: 3] == 3'b001)
              wide_o <= full[DL_BIT];
          end
          CYC_DWR: begin
            wdat_vld_o <= 1'b1;
            wdat_o     <= full;
          end
          CYC_DRD: rack_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbus_rdout.sv
module mbus_rdout #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic          rise_i,
  input  logic          wide_i,
  input  logic          lo_i,
  input  logic          busy_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] dout_o,
  output logic          doe_o
);
  localparam int NW = DW / 2;

  logic [DW-1:0] snap, fresh, cur;
  logic          load;

  always_comb begin
    fresh = sel_i ? rdata_i : {busy_i, addr_i};
    load  = rise_i && (wide_i || !lo_i);
    cur   = load ? fresh : snap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap   <= '0;
      dout_o <= '0;
      doe_o  <= 1'b0;
    end else begin
      if (load) snap <= fresh;
      doe_o <= en_i & rd_i;
      if (en_i && rd_i) begin
        if (wide_i)
          dout_o <= cur;
        else if (lo_i)
          dout_o <= {cur[NW-1:0], {NW{1'b0}}};
        else
          dout_o <= {cur[DW-1 -: NW], {NW{1'b0}}};
      end else begin
        dout_o <= '0;
      end
    end
  end
endmodule

// File: rtl/mbus_front.sv
module mbus_front
  import mbus_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 7,
  parameter int HOLD_CYC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_sel,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic          busy_in,
  input  logic [AW-1:0] ac_in,
  input  logic [DW-1:0] rdreg_in,
  output logic          cmd_vld,
  output logic [DW-1:0] cmd_byte,
  output logic          wdat_vld,
  output logic [DW-1:0] wdat_byte,
  output logic          rdat_ack,
  output logic          wide_mode
);
  logic          rise, fall, busy_eff, lo_phase;
  cyc_kind_t     kind;
  logic [DW-1:0] cap;

  mbus_edge #(.DW(DW)) u_edge (
    .clk(clk), .rst(rst), .en_i(bus_en), .sel_i(bus_sel), .rd_i(bus_rd),
    .din_i(bus_din), .rise_o(rise), .fall_o(fall), .kind_o(kind), .cap_o(cap)
  );

  mbus_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .busy_i(busy_in), .busy_o(busy_eff)
  );

  mbus_assemble #(.DW(DW)) u_asm (
    .clk(clk), .rst(rst), .fall_i(fall), .kind_i(kind), .cap_i(cap),
    .busy_i(busy_eff), .cmd_vld_o(cmd_vld), .cmd_o(cmd_byte),
    .wdat_vld_o(wdat_vld), .wdat_o(wdat_byte), .rack_o(rdat_ack),
    .wide_o(wide_mode), .lo_o(lo_phase)
  );

  mbus_rdout #(.DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .en_i(bus_en), .sel_i(bus_sel), .rd_i(bus_rd),
    .rise_i(rise), .wide_i(wide_mode), .lo_i(lo_phase), .busy_i(busy_eff),
    .addr_i(ac_in), .rdata_i(rdreg_in), .dout_o(bus_dout), .doe_o(bus_doe)
  );
endmodule

// File: rtl/mbus_front_chk.sv
module mbus_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_en,
  input logic          bus_rd,
  input logic          busy_in,
  input logic [DW-1:0] bus_dout,
  input logic          bus_doe,
  input logic          cmd_vld,
  input logic          wdat_vld,
  input logic          rdat_ack,
  input logic          wide_mode
);
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) cmd_vld |=> !cmd_vld); // R2
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({cmd_vld, wdat_vld, rdat_ack})); // R3
  AST_DOE_ON_READ: assert property (@(posedge clk) disable iff (rst) bus_doe |-> $past(bus_en && bus_rd)); // R4
  AST_NIBBLE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_doe && !wide_mode) |-> (bus_dout[3:0] == 4'h0)); // R8
  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst) busy_in |=> (!cmd_vld && !wdat_vld)); // R9
endmodule

bind mbus_front mbus_front_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_rd(bus_rd), .busy_in(busy_in),
  .bus_dout(bus_dout), .bus_doe(bus_doe), .cmd_vld(cmd_vld),
  .wdat_vld(wdat_vld), .rdat_ack(rdat_ack), .wide_mode(wide_mode)
);

// File: tb/tb_mbus_front.sv
module tb_mbus_front;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_sel = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic       bus_doe;
  logic       busy_in = 1'b0;
  logic [6:0] ac_in = 7'h00;
  logic [7:0] rdreg_in = 8'h00;
  logic       cmd_vld, wdat_vld, rdat_ack, wide_mode;
  logic [7:0] cmd_byte, wdat_byte;

  int n_chk = 0;
  int n_err = 0;

  // per-transfer observations
  logic [7:0] t_q;
  logic       t_oe, t_cv, t_wv, t_ra;
  logic [7:0] t_cb, t_wb;

  mbus_front dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe), .busy_in(busy_in),
    .ac_in(ac_in), .rdreg_in(rdreg_in), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .wdat_vld(wdat_vld), .wdat_byte(wdat_byte), .rdat_ack(rdat_ack),
    .wide_mode(wide_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic s, input logic r, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = r; bus_din = d; bus_en = 1'b1;
    repeat (3) @(negedge clk);
    t_q = bus_dout; t_oe = bus_doe;
    bus_en = 1'b0;
    @(negedge clk);
    t_cv = cmd_vld; t_cb = cmd_byte; t_wv = wdat_vld; t_wb = wdat_byte; t_ra = rdat_ack;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 wide", 32'(wide_mode), 1);
    chk("R1 doe", 32'(bus_doe), 0);
    chk("R1 strobes", 32'({cmd_vld, wdat_vld, rdat_ack}), 0);
  endtask

  task automatic t_wide_writes;
    xfer(0, 0, 8'h0C);
    chk("R2 cmd_vld", 32'(t_cv), 1);
    chk("R2 cmd_byte", 32'(t_cb), 32'h0C);
    chk("R2 single cycle", 32'(cmd_vld), 0);
    xfer(1, 0, 8'h41);
    chk("R3 wdat", 32'({t_wv, t_cv, t_ra, t_wb}), 32'h441);
  endtask

  task automatic t_wide_reads;
    ac_in = 7'h25;
    xfer(0, 1, 8'h00);
    chk("R4 status", 32'(t_q), 32'h25);
    chk("R4 doe", 32'(t_oe), 1);
    rdreg_in = 8'h7E;
    xfer(1, 1, 8'h00);
    chk("R5 data", 32'(t_q), 32'h7E);
    chk("R5 ack", 32'(t_ra), 1);
  endtask

  task automatic t_busy_wide;
    busy_in = 1'b1;
    xfer(0, 1, 8'h00);
    chk("R10 status busy", 32'(t_q), 32'hA5);
    xfer(0, 0, 8'h01);
    chk("R9 cmd dropped", 32'(t_cv), 0);
    xfer(1, 0, 8'h55);
    chk("R9 data dropped", 32'(t_wv), 0);
    @(negedge clk); busy_in = 1'b0;
    xfer(0, 0, 8'h02);
    chk("R11 guard drop", 32'(t_cv), 0);
    repeat (12) @(negedge clk);
    xfer(0, 1, 8'h00);
    chk("R11 ready", 32'(t_q), 32'h25);
    xfer(0, 0, 8'h03);
    chk("R11 accepted", 32'({t_cv, t_cb}), 32'h103);
  endtask

  task automatic t_go_narrow;
    xfer(0, 0, 8'h28);
    chk("R6 fnset strobe", 32'({t_cv, t_cb}), 32'h128);
    chk("R6 narrow", 32'(wide_mode), 0);
  endtask

  task automatic t_narrow_writes;
    xfer(0, 0, 8'h8F);
    chk("R7 first nibble no strobe", 32'(t_cv), 0);
    xfer(0, 0, 8'h3A);
    chk("R7 cmd byte", 32'({t_cv, t_cb}), 32'h183);
    xfer(1, 0, 8'hD0);
    chk("R7 data first", 32'(t_wv), 0);
    xfer(1, 0, 8'h20);
    chk("R7 data byte", 32'({t_wv, t_wb}), 32'h1D2);
  endtask

  task automatic t_narrow_reads;
    rdreg_in = 8'hC3;
    xfer(1, 1, 8'h00);
    chk("R8 hi nibble", 32'(t_q), 32'hC0);
    chk("R8 no ack yet", 32'(t_ra), 0);
    rdreg_in = 8'h00;
    xfer(1, 1, 8'h00);
    chk("R8 lo nibble", 32'(t_q), 32'h30);
    chk("R8 ack", 32'(t_ra), 1);
    xfer(0, 1, 8'h00);
    chk("R4 status hi", 32'(t_q), 32'h20);
    xfer(0, 1, 8'h00);
    chk("R4 status lo", 32'(t_q), 32'h50);
  endtask

  task automatic t_narrow_busy;
    busy_in = 1'b1;
    xfer(0, 0, 8'hA0);
    chk("R9 nibble dropped", 32'(t_cv), 0);
    @(negedge clk); busy_in = 1'b0;
    repeat (12) @(negedge clk);
    xfer(0, 0, 8'h50);
    chk("R9 phase kept", 32'(t_cv), 0);
    xfer(0, 0, 8'h60);
    chk("R9 phase byte", 32'({t_cv, t_cb}), 32'h156);
  endtask

  task automatic t_go_wide;
    xfer(0, 0, 8'h30);
    xfer(0, 0, 8'h00);
    chk("R6 fnset nibbles", 32'({t_cv, t_cb}), 32'h130);
    chk("R6 wide again", 32'(wide_mode), 1);
    xfer(1, 0, 8'h99);
    chk("R6 wide write", 32'({t_wv, t_wb}), 32'h199);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wide_writes();
    t_wide_reads();
    t_busy_wide();
    t_go_narrow();
    t_narrow_writes();
    t_narrow_reads();
    t_narrow_busy();
    t_go_wide();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule